// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of one of two input signals. It counts rising edges of the chosen signal while a gate window is open. A free-running timebase produces one tick per millisecond of system time. A start command arms the block, and the window opens on the next tick. It then stays open for 1, 4, 16 or 64 ticks, as a 2-bit code selects. When the window closes the count stays on the result port until the next start.

The measured signal is either the direct IF input or the oscillator prescaler clock. In high-frequency mode the prescaler clock is divided by 16 before it is counted. In low-frequency mode it is counted without division. Both inputs pass through a two-flop synchronizer and a rising-edge detector, so the whole design runs on one system clock. A busy flag covers the time from the start command to the end of the window. A sticky overflow flag reports that the counter passed its full-scale value. A parameter selects whether the count then saturates at full scale or wraps around.

Top module: `ifc_freq_meter`

## Requirements
- R1: After a synchronous reset, `busy`, `over` and `count` are all zero.
- R2: A write with `cmd_start` = 1 while idle sets `busy` on the next clock edge. On that same edge it clears `count` and `over`.
- R3: The gate opens on the first timebase tick after the start is accepted. `busy` is therefore high for between N*TICK_DIV+1 and N*TICK_DIV+TICK_DIV cycles, where N is the window length in ticks.
- R4: `gate_sel` codes 0, 1, 2 and 3 give windows of 1, 4, 16 and 64 ticks. The result equals the number of rising edges of the selected source seen inside the window.
- R5: `src_psc` = 0 counts `if_in`. `src_psc` = 1 counts `psc_in`. The input that is not selected has no effect on the result.
- R6: With `src_psc` = 1 and `hf_mode` = 1, the count is one sixteenth of the number of prescaler edges. `hf_mode` has no effect when `src_psc` = 0.
- R7: `busy` clears when the window closes. After that, `count` holds its value while the inputs keep toggling.
- R8: If the count passes 2^CNT_W-1, `over` is set and stays set. With SATURATE = 1 the count stays at 2^CNT_W-1. With SATURATE = 0 the count continues modulo 2^CNT_W.
- R9: A new start clears a set `over` flag.
- R10: A write with `cmd_start` = 0 during a measurement aborts it. `busy` is low on the next cycle, and `count` is frozen from then on.
- R11: A write with `cmd_start` = 1 while `busy` is high is ignored. The window in progress is neither restarted nor cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Control write strobe |
| cmd_start | input | 1 | Start/stop bit: 1 starts, 0 aborts |
| gate_sel | input | 2 | Window code, captured at start |
| src_psc | input | 1 | Source select: 0 IF input, 1 prescaler clock; captured at start |
| hf_mode | input | 1 | High-frequency mode: prescaler divided by 16; captured at start |
| if_in | input | 1 | Asynchronous IF signal |
| psc_in | input | 1 | Asynchronous prescaler clock |
| busy | output | 1 | Measurement armed or gate open |
| over | output | 1 | Sticky overflow flag |
| count | output | CNT_W | Edge count result |

## Verification
Input periods are chosen so that the window length is an exact multiple of the edge period, which makes the expected counts exact. A design that opens the gate one cycle early or late, or picks the wrong window length, gives a wrong count. A wrong divider in high-frequency mode scales the count by a wrong factor. Two narrow-counter copies are driven with the same stimulus so that saturation, wrap-around and the sticky overflow flag are reached. The bench checks that a later start clears `over`, and catches a design that lets the flag leak into the next measurement. It also aborts a measurement and repeats a start in mid-window. A design that restarts on the repeated start stays busy too long, and one that keeps counting after an abort changes its result.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  localparam int REM_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_OPEN = 2'd2
  } gate_state_e;

  function automatic logic [REM_W-1:0] gate_ticks(input logic [1:0] code);
    return 7'd1 << {code, 1'b0};
  endfunction
endpackage

// File: rtl/ifc_edge_sync.sv
module ifc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
      prev_q <= sync_q[SYNC_STAGES-1];
      rise_q <= sync_q[SYNC_STAGES-1] & ~prev_q;
    end
  end

  assign rise_o = rise_q;

  // R4: only rising edges are counted; two pulses never come back to back
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ifc_src_sel.sv
module ifc_src_sel #(
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic if_in,
  input  logic psc_in,
  input  logic sel_psc,
  input  logic hf_mode,
  output logic pulse_o
);
  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0] raw_in;
  logic [NUM_SRC-1:0] rise;
  logic [DIV_LOG2-1:0] div_q;
  logic div_hit;
  logic psc_pulse;
  logic pulse_q;

  assign raw_in = {psc_in, if_in};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    ifc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (raw_in[i]),
      .rise_o   (rise[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else if (rise[1]) div_q <= div_q + 1'b1;
  end

  assign div_hit   = rise[1] && (div_q == {DIV_LOG2{1'b1}});
  assign psc_pulse = hf_mode ? div_hit : rise[1];

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= sel_psc ? psc_pulse : rise[0];
  end

  assign pulse_o = pulse_q;

  // R5: a count pulse always follows an edge on one of the inputs
  assert_pulse_from_edge_R5: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> $past(rise != '0));
  // R6: in divided mode a pulse needs the divider at its last state
  assert_div_only_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && $past(sel_psc && hf_mode)) |-> (div_q == '0));
endmodule

// File: rtl/ifc_gate_ctrl.sv
module ifc_gate_ctrl
  import ifc_pkg::*;
#(
  parameter int TICK_DIV = 250000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic       cmd_start,
  input  logic [1:0] gate_code,
  output logic       accept_o,
  output logic       busy_o,
  output logic       gate_o
);
  localparam int TICK_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [TICK_W-1:0] tcnt_q;
  logic              tick;
  gate_state_e       state_q;
  logic [REM_W-1:0]  rem_q;
  logic [REM_W-1:0]  len_q;
  logic              stop_req;

  always_ff @(posedge clk) begin
    if (rst || tick) tcnt_q <= '0;
    else             tcnt_q <= tcnt_q + 1'b1;
  end
  assign tick = (tcnt_q == TICK_W'(TICK_DIV - 1));

  assign accept_o = (state_q == ST_IDLE) && cmd_wr && cmd_start;
  assign stop_req = (state_q != ST_IDLE) && cmd_wr && !cmd_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      len_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_o) begin
          state_q <= ST_ARM;
          len_q   <= gate_ticks(gate_code);
        end
        ST_ARM: begin
          if (stop_req) state_q <= ST_IDLE;
          else if (tick) begin
            state_q <= ST_OPEN;
            rem_q   <= len_q;
          end
        end
        ST_OPEN: begin
          if (stop_req) state_q <= ST_IDLE;
          else if (tick) begin
            if (rem_q == REM_W'(1)) state_q <= ST_IDLE;
            else                    rem_q   <= rem_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign gate_o = (state_q == ST_OPEN);

  // R3: the gate opens only on a timebase tick
  assert_gate_opens_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> $past(tick));
  // R7 / R10: busy drops only at a tick or on an abort
  assert_busy_end_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> ($past(tick) || $past(cmd_wr && !cmd_start)));
  // R11: a start during an open window leaves it open
  assert_restart_ignored_R11: assert property (@(posedge clk) disable iff (rst)
    (gate_o && cmd_wr && cmd_start && !tick) |=> gate_o);
endmodule

// File: rtl/ifc_bin_counter.sv
module ifc_bin_counter #(
  parameter int CNT_W    = 20,
  parameter bit SATURATE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_o,
  output logic             over_o
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             over_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else if (inc) begin
      if (cnt_q == FULL) begin
        over_q <= 1'b1;
        if (!SATURATE) cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign over_o = over_q;

  // R2: a start clears both result and flag
  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_o == '0 && !over_o));
  // R7: without count pulses the result holds
  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!clr && !inc) |=> $stable(cnt_o));
  // R8: overflow flag is sticky
  assert_no_overflow_loss_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && over_o) |=> over_o);
  // R8: a pulse at full scale raises the flag
  assert_overflow_flagged_R8: assert property (@(posedge clk) disable iff (rst)
    (!clr && inc && cnt_o == FULL) |=> over_o);
endmodule

// File: rtl/ifc_freq_meter.sv
module ifc_freq_meter #(
  parameter int CNT_W       = 20,
  parameter int TICK_DIV    = 250000,
  parameter bit SATURATE    = 1'b1,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LOG2    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic             cmd_start,
  input  logic [1:0]       gate_sel,
  input  logic             src_psc,
  input  logic             hf_mode,
  input  logic             if_in,
  input  logic             psc_in,
  output logic             busy,
  output logic             over,
  output logic [CNT_W-1:0] count
);
  logic accept;
  logic gate;
  logic pulse;
  logic sel_q;
  logic hf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      hf_q  <= 1'b0;
    end else if (accept) begin
      sel_q <= src_psc;
      hf_q  <= hf_mode;
    end
  end

  ifc_gate_ctrl #(.TICK_DIV(TICK_DIV)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_start (cmd_start),
    .gate_code (gate_sel),
    .accept_o  (accept),
    .busy_o    (busy),
    .gate_o    (gate)
  );

  ifc_src_sel #(.SYNC_STAGES(SYNC_STAGES), .DIV_LOG2(DIV_LOG2)) u_src (
    .clk     (clk),
    .rst     (rst),
    .if_in   (if_in),
    .psc_in  (psc_in),
    .sel_psc (sel_q),
    .hf_mode (hf_q),
    .pulse_o (pulse)
  );

  ifc_bin_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .inc    (gate && pulse),
    .cnt_o  (count),
    .over_o (over)
  );

  // R10: nothing is counted while idle
  assert_idle_frozen_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !accept) |=> $stable(count));
endmodule

// File: tb/ifc_freq_meter_bench.sv
`timescale 1ns/1ps
module ifc_freq_meter_bench;
  localparam int T  = 32;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wr = 1'b0, cmd_start = 1'b0;
  logic [1:0] gate_sel = 2'd0;
  logic src_psc = 1'b0, hf_mode = 1'b0;
  logic if_in = 1'b0, psc_in = 1'b0;
  logic busy, over, busy_s, over_s, busy_w, over_w;
  logic [19:0] count;
  logic [SW-1:0] count_s, count_w;

  int total = 0, bad = 0;
  int if_half = 3, psc_half = 3, ifc = 0, pc = 0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    if (ifc >= if_half - 1) begin ifc = 0; if_in = ~if_in; end else ifc++;
    if (pc >= psc_half - 1) begin pc = 0; psc_in = ~psc_in; end else pc++;
  end

  ifc_freq_meter #(.CNT_W(20), .TICK_DIV(T)) u_ifc_freq_meter (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_start(cmd_start), .gate_sel(gate_sel),
    .src_psc(src_psc), .hf_mode(hf_mode), .if_in(if_in), .psc_in(psc_in),
    .busy(busy), .over(over), .count(count));
  ifc_freq_meter #(.CNT_W(SW), .TICK_DIV(T), .SATURATE(1'b1)) u_sat (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_start(cmd_start), .gate_sel(gate_sel),
    .src_psc(src_psc), .hf_mode(hf_mode), .if_in(if_in), .psc_in(psc_in),
    .busy(busy_s), .over(over_s), .count(count_s));
  ifc_freq_meter #(.CNT_W(SW), .TICK_DIV(T), .SATURATE(1'b0)) u_wrap (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_start(cmd_start), .gate_sel(gate_sel),
    .src_psc(src_psc), .hf_mode(hf_mode), .if_in(if_in), .psc_in(psc_in),
    .busy(busy_w), .over(over_w), .count(count_w));

  localparam int NV = 8;
  localparam int VG[NV]    = '{0, 1, 2, 3, 1, 2, 3, 3};
  localparam int VS[NV]    = '{0, 0, 0, 0, 1, 1, 1, 1};
  localparam int VH[NV]    = '{0, 0, 1, 0, 0, 1, 1, 0};
  localparam int VHALF[NV] = '{4, 2, 4, 4, 4, 4, 2, 8};
  localparam int VEXP[NV]  = '{4, 32, 64, 256, 16, 4, 32, 128};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_cmd(input bit st);
    cmd_wr = 1'b1; cmd_start = st;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_start = 1'b0;
  endtask

  task automatic wait_idle(output int dur);
    dur = 0;
    while (busy) begin dur++; @(negedge clk); end
  endtask

  task automatic measure(input int g, input bit s, input bit h, output int dur);
    gate_sel = 2'(g); src_psc = s; hf_mode = h;
    start_cmd(1'b1);
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    chk(count == 0, "R2", "count cleared", count, 0);
    chk(over_s == 1'b0, "R2", "over cleared", over_s, 0);
    wait_idle(dur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int dur, n, held, exp_s, exp_w;
    repeat (5) @(negedge clk);
    chk(busy == 0 && over == 0 && count == 0, "R1", "reset state", {busy, over, count != 0}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && count == 0, "R1", "after reset release", count, 0);

    // table-driven measurements: R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      if (VS[v]) begin psc_half = VHALF[v]; if_half = 3; end
      else       begin if_half = VHALF[v]; psc_half = 3; end
      repeat (4) @(negedge clk);
      n = 1 << (2 * VG[v]);
      measure(VG[v], VS[v] != 0, VH[v] != 0, dur);
      chk(dur >= n * T + 1 && dur <= n * T + T, "R3", "busy length", dur, n * T);
      chk(count == VEXP[v], "R4", "count (R5 source, R6 divide)", count, VEXP[v]);
      chk(over == 1'b0, "R8", "wide counter no overflow", over, 0);
      exp_s = (VEXP[v] > 63) ? 63 : VEXP[v];
      exp_w = VEXP[v] % 64;
      chk(count_s == exp_s, "R8", "saturating count", count_s, exp_s);
      chk(count_w == exp_w, "R8", "wrapping count", count_w, exp_w);
      chk(over_s == (VEXP[v] > 63) && over_w == (VEXP[v] > 63), "R8", "overflow flag",
          over_s, VEXP[v] > 63);
    end

    // R7: result held after the window while inputs toggle
    held = count;
    repeat (40) @(negedge clk);
    chk(count == held, "R7", "count held after close", count, held);
    chk(over_s == 1'b1, "R8", "over sticky", over_s, 1);

    // R9: new start clears over
    if_half = 4;
    repeat (4) @(negedge clk);
    measure(0, 1'b0, 1'b0, dur);
    chk(over_s == 1'b0 && over_w == 1'b0, "R9", "over cleared by start", over_s, 0);
    chk(count_s == 4, "R9", "small count", count_s, 4);

    // R10: abort mid-window
    gate_sel = 2'd3; src_psc = 1'b0; hf_mode = 1'b0;
    start_cmd(1'b1);
    repeat (300) @(negedge clk);
    start_cmd(1'b0);
    chk(busy == 1'b0, "R10", "busy after abort", busy, 0);
    held = count;
    chk(held > 0, "R10", "partial count nonzero", held, 1);
    repeat (60) @(negedge clk);
    chk(count == held, "R10", "count frozen after abort", count, held);

    // R11: repeated start inside the window is ignored
    gate_sel = 2'd1;
    start_cmd(1'b1);
    repeat (99) @(negedge clk);
    gate_sel = 2'd3;
    start_cmd(1'b1);
    wait_idle(dur);
    dur += 101;
    chk(dur >= 4 * T + 1 && dur <= 4 * T + T, "R11", "window not restarted", dur, 4 * T);
    chk(count == 16, "R11", "count of original window", count, 16);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule